// File: doc/BRIEF.md
# Streaming CRC Appender

This block sits inline on a 32-bit valid/ready word stream and appends a checksum word to every packet. Payload words flow straight through, unchanged and in order, while a 32-bit CRC is folded over them one whole word per clock. When the word flagged as the end of a packet has been accepted, the block emits one extra word that carries the finished CRC and the end-of-packet flag. Each packet on the output is therefore exactly one word longer than on the input.

The polynomial, seed, final XOR mask and the two reflection switches arrive as static inputs from a register bank elsewhere. They are captured when a packet's first word is accepted and held until that packet's CRC word has left, so the bank may be rewritten at any moment without corrupting a packet already in flight.

Back-pressure rules: during payload the input side is ready exactly when the output side is ready, and the output is valid exactly when the input is valid, so a word moves through in the cycle both handshakes hold and is never dropped or repeated. While the CRC word is pending, the input side is not ready, and the CRC word is held, stable and valid, until the output side is ready.

Top module: `crc_stream_appender`

## Requirements
- R1: A payload word is presented on the output with the same data as the input, in input order, with out_last low.
- R2: The output word following an accepted input word that has in_last high is the CRC word with out_last high; exactly one such word follows each packet, and the next packet's payload comes after it.
- R3: The CRC starts from cfg_seed and processes each word's four bytes from bits [31:24] down to bits [7:0]; each byte is shifted in bit 7 first into a left-shifting register, and the register is XORed with cfg_poly whenever the bit leaving bit 31 differs from the incoming data bit. With seed 0, mask 0 and no reflection, an all-zero packet yields a CRC of 0.
- R4: With cfg_reflect[0] high, each input byte is bit-reversed before being shifted in. With polynomial 0x04C11DB7, seed and mask 0xFFFFFFFF and cfg_reflect = 2'b11, the words 0x31323334, 0x35363738 give a CRC word of 0x9AE0DAAF.
- R5: With cfg_reflect[1] high, the 32-bit register is bit-reversed before the final XOR; cfg_xorout is always XORed in last, so seed 0, zero data and mask 0xA5A5A5A5 give 0xA5A5A5A5.
- R6: While no CRC word is pending, in_ready equals out_ready and out_valid equals in_valid in the same cycle.
- R7: While the CRC word is pending, in_ready is low, out_valid is high, and out_data stays unchanged until out_ready is high.
- R8: Every packet starts from the seed, so the CRC of a packet does not depend on earlier packets.
- R9: The four configuration inputs are sampled when a packet's first word is accepted; changes to them after that, up to the acceptance of that packet's CRC word, have no effect on its CRC.
- R10: Reset discards any partly received packet and any pending CRC word; after reset, with in_valid low, out_valid and out_last are low, and the next packet's CRC starts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_poly | input | 32 | CRC polynomial, normal (non-reflected) form |
| cfg_seed | input | 32 | CRC register start value |
| cfg_xorout | input | 32 | Mask XORed onto the finished CRC |
| cfg_reflect | input | 2 | Bit 0: reverse each input byte; bit 1: reverse the CRC before the mask |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input payload word |
| in_last | input | 1 | Input word is the last of its packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Payload word or CRC word |
| out_last | output | 1 | Output word is the appended CRC word |

## Verification
On every cycle the checker holds the handshake rules: input and output ready tracking each other during payload, payload data passing through untouched, the CRC word following the end-of-packet word, the input stalled and the CRC word frozen while it waits, and payload resuming once it is taken. The CRC value itself, per-packet independence, sampling of the configuration at the first word, and recovery from a reset in mid-packet can only be shown by the bench scenarios, which compare every output word against a bitwise reference model and a few fixed check values.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;

  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;

  // Configuration captured per packet
  typedef struct packed {
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] xorout;
    logic             refl_in;
    logic             refl_out;
  } crc_cfg_t;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,  // waiting for the first word of a packet
    ST_BODY = 2'd1,  // inside a packet
    ST_TAIL = 2'd2   // CRC word pending on the output
  } app_state_e;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] rev_word(input logic [CRC_W-1:0] w);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = w[CRC_W-1-i];
    return r;
  endfunction

  // Shift one byte into the register, bit 7 first
  function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c_in,
                                                      input logic [BYTE_W-1:0] b,
                                                      input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ b[i]) c = (c << 1) ^ poly;
      else                   c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/crc_word_engine.sv
module crc_word_engine
  import crc_app_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CRC_W-1:0]  poly,
  input  logic              refl_in,
  output logic [CRC_W-1:0]  crc_out
);

  localparam int NB = DATA_W / BYTE_W;

  logic [CRC_W-1:0] stage [0:NB];

  assign stage[0] = crc_in;

  // One unrolled stage per byte, most significant byte first
  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int LSB = (NB - 1 - g) * BYTE_W;
    logic [BYTE_W-1:0] raw;
    logic [BYTE_W-1:0] din;
    assign raw          = data_in[LSB +: BYTE_W];
    assign din          = refl_in ? rev_byte(raw) : raw;
    assign stage[g + 1] = crc_byte_step(stage[g], din, poly);
  end

  assign crc_out = stage[NB];

endmodule

// File: rtl/crc_finalize.sv
module crc_finalize
  import crc_app_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic              refl_out,
  input  logic [CRC_W-1:0]  xorout,
  output logic [DATA_W-1:0] word_out
);

  logic [CRC_W-1:0] oriented;

  assign oriented = refl_out ? rev_word(crc_in) : crc_in;
  assign word_out = DATA_W'(oriented ^ xorout);

endmodule

// File: rtl/crc_cfg_hold.sv
module crc_cfg_hold
  import crc_app_pkg::*;
#(
  parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] RST_SEED = 32'h0000_0000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  crc_cfg_t live_cfg,
  output crc_cfg_t held_cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_cfg.poly     <= RST_POLY;
      held_cfg.seed     <= RST_SEED;
      held_cfg.xorout   <= '0;
      held_cfg.refl_in  <= 1'b0;
      held_cfg.refl_out <= 1'b0;
    end else if (capture) begin
      held_cfg <= live_cfg;
    end
  end

endmodule

// File: rtl/crc_stream_appender.sv
module crc_stream_appender
  import crc_app_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] RST_SEED = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRC_W-1:0]  cfg_poly,
  input  logic [CRC_W-1:0]  cfg_seed,
  input  logic [CRC_W-1:0]  cfg_xorout,
  input  logic [1:0]        cfg_reflect,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  app_state_e       state_q;
  logic [CRC_W-1:0] crc_q;
  crc_cfg_t         live_cfg;
  crc_cfg_t         held_cfg;

  logic             opening;
  logic             in_beat;
  logic             tail_done;
  logic [CRC_W-1:0] eff_poly;
  logic [CRC_W-1:0] eff_seed;
  logic             eff_refl_in;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;
  logic [DATA_W-1:0] crc_word;

  assign live_cfg = '{poly:     cfg_poly,
                      seed:     cfg_seed,
                      xorout:   cfg_xorout,
                      refl_in:  cfg_reflect[0],
                      refl_out: cfg_reflect[1]};

  // First word of a packet uses the live settings; later words use the held copy
  assign opening     = (state_q == ST_OPEN);
  assign eff_poly    = opening ? live_cfg.poly    : held_cfg.poly;
  assign eff_seed    = opening ? live_cfg.seed    : held_cfg.seed;
  assign eff_refl_in = opening ? live_cfg.refl_in : held_cfg.refl_in;
  assign crc_base    = opening ? eff_seed         : crc_q;

  assign in_beat   = in_valid && in_ready;
  assign tail_done = (state_q == ST_TAIL) && out_ready;

  crc_cfg_hold #(
    .RST_POLY (RST_POLY),
    .RST_SEED (RST_SEED)
  ) cfg_hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (opening && in_beat),
    .live_cfg (live_cfg),
    .held_cfg (held_cfg)
  );

  crc_word_engine #(
    .DATA_W (DATA_W)
  ) engine_i (
    .crc_in  (crc_base),
    .data_in (in_data),
    .poly    (eff_poly),
    .refl_in (eff_refl_in),
    .crc_out (crc_next)
  );

  crc_finalize #(
    .DATA_W (DATA_W)
  ) finalize_i (
    .crc_in   (crc_q),
    .refl_out (held_cfg.refl_out),
    .xorout   (held_cfg.xorout),
    .word_out (crc_word)
  );

  // Output steering: pass-through during payload, CRC word in the tail
  always_comb begin
    if (state_q == ST_TAIL) begin
      out_valid = 1'b1;
      out_data  = crc_word;
      out_last  = 1'b1;
      in_ready  = 1'b0;
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = 1'b0;
      in_ready  = out_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      crc_q   <= RST_SEED;
    end else begin
      unique case (state_q)
        ST_OPEN, ST_BODY: begin
          if (in_beat) begin
            crc_q   <= crc_next;
            state_q <= in_last ? ST_TAIL : ST_BODY;
          end
        end
        ST_TAIL: begin
          if (tail_done) begin
            crc_q   <= held_cfg.seed;
            state_q <= ST_OPEN;
          end
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end

endmodule

// File: rtl/crc_stream_appender_chk.sv
module crc_stream_appender_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);

  logic crc_pending;
  assign crc_pending = out_valid && out_last;

  // R1: payload words pass through untouched
  p_payload_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (in_valid && out_data == in_data));

  // R2: end-of-packet word is followed by the CRC word
  p_tail_follows_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && out_last));

  // R2: only one CRC word per packet
  p_single_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_pending && out_ready) |=> !out_last);

  // R6: ready tracks downstream during payload
  p_ready_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_pending |-> (in_ready == out_ready));

  // R7: input stalled while CRC word waits
  p_input_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_pending |-> !in_ready);

  // R7: waiting CRC word is held stable
  p_tail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_pending && !out_ready) |=> (crc_pending && $stable(out_data)));

endmodule

bind crc_stream_appender crc_stream_appender_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/crc_stream_appender_tb_top.sv
module crc_stream_appender_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_poly = 32'h04C11DB7;
  logic [31:0] cfg_seed = '0;
  logic [31:0] cfg_xorout = '0;
  logic [1:0]  cfg_reflect = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;

  always #5 clk = ~clk;

  crc_stream_appender dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_poly(cfg_poly), .cfg_seed(cfg_seed), .cfg_xorout(cfg_xorout), .cfg_reflect(cfg_reflect),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // stimulus store
  logic [31:0] st_data [0:1023];
  bit          st_last [0:1023];
  int          st_pkt  [0:1023];
  logic [31:0] pk_poly [0:127];
  logic [31:0] pk_seed [0:127];
  logic [31:0] pk_xor  [0:127];
  logic [1:0]  pk_refl [0:127];
  int st_cnt, pk_cnt, in_ptr, out_total;

  // expected and observed output
  logic [31:0] ex_data [0:1279];
  bit          ex_last [0:1279];
  logic [31:0] ob_data [0:1279];
  int ex_cnt, ob_cnt, pkt_start;

  int    vld_pct, rdy_pct;
  bit    garble;
  string crc_tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference CRC, walked as a bit stream over the stored packet
  function automatic logic [31:0] ref_crc(input int first, input int last_idx, input int pk);
    logic [31:0] c;
    logic [7:0]  b;
    logic [31:0] r;
    c = pk_seed[pk];
    for (int w = first; w <= last_idx; w++) begin
      for (int k = 3; k >= 0; k--) begin
        b = st_data[w][k*8 +: 8];
        if (pk_refl[pk][0]) b = {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
        for (int j = 7; j >= 0; j--) begin
          if (c[31] != b[j]) c = {c[30:0], 1'b0} ^ pk_poly[pk];
          else               c = {c[30:0], 1'b0};
        end
      end
    end
    if (pk_refl[pk][1]) begin
      for (int i = 0; i < 32; i++) r[i] = c[31-i];
      c = r;
    end
    return c ^ pk_xor[pk];
  endfunction

  task automatic clear_store();
    st_cnt = 0; pk_cnt = 0; in_ptr = 0; out_total = 0;
    ex_cnt = 0; ob_cnt = 0; pkt_start = 0;
  endtask

  task automatic add_pkt(input int len, input logic [31:0] poly, input logic [31:0] seed,
                         input logic [31:0] xr, input logic [1:0] refl, input bit with_last);
    pk_poly[pk_cnt] = poly; pk_seed[pk_cnt] = seed; pk_xor[pk_cnt] = xr; pk_refl[pk_cnt] = refl;
    for (int i = 0; i < len; i++) begin
      st_data[st_cnt] = $urandom;
      st_last[st_cnt] = with_last && (i == len - 1);
      st_pkt[st_cnt]  = pk_cnt;
      st_cnt++;
    end
    out_total += with_last ? len + 1 : len;
    pk_cnt++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: nothing presented after reset with no input offered
    chk(out_valid == 1'b0, "R10", {31'd0, out_valid}, 32'd0);
    chk(out_last == 1'b0, "R10", {31'd0, out_last}, 32'd0);
  endtask

  task automatic run_stream();
    int          pk;
    int          cyc;
    bit          prev_wait;
    logic [31:0] prev_data;
    cyc = 0; prev_wait = 0; prev_data = '0;
    while ((ob_cnt < out_total || in_ptr < st_cnt) && cyc < 5000) begin
      @(posedge clk); #1;
      cyc++;
      if (in_ptr < st_cnt) begin
        pk       = st_pkt[in_ptr];
        in_valid = (($urandom % 100) < vld_pct);
        in_data  = st_data[in_ptr];
        in_last  = st_last[in_ptr];
        if (in_ptr == 0 || st_pkt[in_ptr-1] != pk) begin
          cfg_poly = pk_poly[pk]; cfg_seed = pk_seed[pk];
          cfg_xorout = pk_xor[pk]; cfg_reflect = pk_refl[pk];
        end else if (garble && (($urandom % 2) == 0)) begin
          cfg_poly = $urandom; cfg_seed = $urandom;
          cfg_xorout = $urandom; cfg_reflect = 2'($urandom);
        end
      end else begin
        in_valid = 1'b0; in_last = 1'b0; in_data = $urandom;
        if (garble) begin cfg_seed = $urandom; cfg_xorout = $urandom; cfg_reflect = 2'($urandom); end
      end
      out_ready = (($urandom % 100) < rdy_pct);
      @(negedge clk);
      if (out_valid && out_last) begin
        chk(in_ready == 1'b0, "R7", {31'd0, in_ready}, 32'd0);
        if (prev_wait) chk(out_data == prev_data, "R7", out_data, prev_data);
      end else begin
        chk(in_ready == out_ready, "R6", {31'd0, in_ready}, {31'd0, out_ready});
        chk(out_valid == in_valid, "R6", {31'd0, out_valid}, {31'd0, in_valid});
      end
      if (in_valid && in_ready) begin
        if (in_ptr == 0 || st_pkt[in_ptr-1] != st_pkt[in_ptr]) pkt_start = in_ptr;
        ex_data[ex_cnt] = st_data[in_ptr]; ex_last[ex_cnt] = 1'b0; ex_cnt++;
        if (st_last[in_ptr]) begin
          ex_data[ex_cnt] = ref_crc(pkt_start, in_ptr, st_pkt[in_ptr]);
          ex_last[ex_cnt] = 1'b1; ex_cnt++;
        end
        in_ptr++;
      end
      if (out_valid && out_ready) begin
        if (ob_cnt >= ex_cnt) begin
          chk(1'b0, "R2", out_data, 32'd0);
        end else begin
          ob_data[ob_cnt] = out_data;
          chk(out_data == ex_data[ob_cnt], ex_last[ob_cnt] ? crc_tag : "R1", out_data, ex_data[ob_cnt]);
          chk(out_last == ex_last[ob_cnt], "R2", {31'd0, out_last}, {31'd0, ex_last[ob_cnt]});
        end
        ob_cnt++;
      end
      prev_wait = out_valid && out_last && !out_ready;
      prev_data = out_data;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    chk(ob_cnt == out_total, "R2", ob_cnt, out_total);
  endtask

  function automatic logic [31:0] pick_poly();
    case ($urandom % 3)
      0:       return 32'h04C11DB7;
      1:       return 32'h1EDC6F41;
      default: return $urandom | 32'h1;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7391));
    do_reset();

    // R3: zero data from zero seed gives zero
    clear_store(); vld_pct = 100; rdy_pct = 100; garble = 0; crc_tag = "R3";
    add_pkt(3, 32'h04C11DB7, 32'h0, 32'h0, 2'b00, 1);
    for (int i = 0; i < 3; i++) st_data[i] = '0;
    run_stream();
    chk(ob_data[3] == 32'h0, "R3", ob_data[3], 32'h0);

    // R4: byte-reflected reference vector
    clear_store(); crc_tag = "R4";
    add_pkt(2, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11, 1);
    st_data[0] = 32'h31323334; st_data[1] = 32'h35363738;
    run_stream();
    chk(ob_data[2] == 32'h9AE0DAAF, "R4", ob_data[2], 32'h9AE0DAAF);

    // R5: final mask applied last
    clear_store(); crc_tag = "R5";
    add_pkt(1, 32'h04C11DB7, 32'h0, 32'hA5A5A5A5, 2'b10, 1);
    st_data[0] = '0;
    run_stream();
    chk(ob_data[1] == 32'hA5A5A5A5, "R5", ob_data[1], 32'hA5A5A5A5);

    // R5: reflected output with random settings, full throughput
    clear_store();
    for (int p = 0; p < 6; p++) add_pkt(1 + ($urandom % 4), pick_poly(), $urandom, $urandom, 2'b10, 1);
    run_stream();

    // R8: back-to-back packets sharing one configuration
    clear_store(); crc_tag = "R8";
    for (int p = 0; p < 8; p++) add_pkt(1 + ($urandom % 5), 32'h1EDC6F41, 32'h12345678, 32'h0, 2'b01, 1);
    run_stream();

    // R9: random traffic and back-pressure, configuration churned mid-packet
    clear_store(); crc_tag = "R9"; vld_pct = 70; rdy_pct = 55; garble = 1;
    for (int p = 0; p < 40; p++) add_pkt(1 + ($urandom % 8), pick_poly(), $urandom, $urandom, 2'($urandom), 1);
    run_stream();

    // R7: heavy downstream stall
    clear_store(); crc_tag = "R7"; vld_pct = 90; rdy_pct = 20; garble = 0;
    for (int p = 0; p < 10; p++) add_pkt(1 + ($urandom % 3), pick_poly(), $urandom, $urandom, 2'($urandom), 1);
    run_stream();

    // R10: reset in mid-packet, next packet starts clean
    clear_store(); vld_pct = 100; rdy_pct = 100;
    add_pkt(3, 32'h04C11DB7, 32'hDEADBEEF, 32'h0, 2'b00, 0);
    run_stream();
    do_reset();
    clear_store(); crc_tag = "R10";
    add_pkt(2, 32'h04C11DB7, 32'h0, 32'h0, 2'b00, 1);
    st_data[0] = '0; st_data[1] = '0;
    run_stream();
    chk(ob_data[2] == 32'h0, "R10", ob_data[2], 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule